// File: doc/BRIEF.md
# Blanked Cycle-by-Cycle Current Limiter

This block cuts short the active lower-switch pulse of a bridge PWM stage when the sensed switch current goes above a fixed limit. Two strobes mark each pulse: one where the pulse begins and one where the modulator ends it on its own. The block takes a digitised current-sense sample and also an over-threshold flag from an external comparator. Either input can trip it.

For a programmable number of clock cycles after each pulse begins, the block ignores the sense inputs. This blanking window hides the switching spike at turn-on. After the window the block is armed. The first cycle in which an armed pulse sees overcurrent produces a one-cycle terminate strobe, and the modulator uses that strobe to end the pulse early. The result is duty reduction on a pulse-by-pulse basis. Nothing latches. The next pulse start re-arms the block, so a steady overload keeps shortening every pulse without ever shutting the stage down.

The block also drives a discharge control for the sense and ramp nodes. This control is high from the end of a pulse, whether it ended naturally or by termination, until the next pulse begins.

Top module: `ocl_current_limiter`

## Requirements
- R1: In reset and in the first cycle after it, `term_o` is 0 and `discharge_o` is 1.
- R2: Overcurrent means `sense_i` is strictly greater than the parameter LIMIT (default 1000, the 1.00 point of the sense scale), or `over_flag_i` is 1. A value equal to LIMIT does not trip.
- R3: Overcurrent is ignored in the cycle that carries `pulse_start_i` and in the following `blank_len_i` cycles.
- R4: When a pulse is armed and overcurrent is present in cycle c, `term_o` is 1 in cycle c+1 only.
- R5: A pulse produces at most one termination. After a termination, overcurrent has no effect until the next pulse start.
- R6: A `pulse_end_i` during an active pulse (blanking or armed) with no armed overcurrent ends the pulse without a terminate strobe.
- R7: `discharge_o` is 1 from the cycle after a pulse ends (natural end or termination) until the cycle that carries the next `pulse_start_i`. It is 0 from the cycle after that start.
- R8: If armed overcurrent and `pulse_end_i` fall in the same cycle, the terminate strobe is still issued.
- R9: With `blank_len_i` = 0, the pulse is armed from the cycle after its start.
- R10: Overcurrent that persists across many pulses terminates each of them. The block neither shuts down nor latches.
- R11: A `pulse_start_i` during an active pulse restarts the blanking window from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_start_i | input | 1 | One-cycle strobe: lower-switch pulse begins |
| pulse_end_i | input | 1 | One-cycle strobe: modulator ends pulse naturally |
| sense_i | input | SENSE_W | Sampled current-sense value |
| over_flag_i | input | 1 | External over-threshold flag |
| blank_len_i | input | BLANK_W | Blanking window length in clock cycles |
| term_o | output | 1 | One-cycle pulse-terminate strobe |
| discharge_o | output | 1 | Sense/ramp node discharge control |

## Verification
Both outputs are registered. The bench drives each cycle's inputs at the falling edge and reads the outputs at the next falling edge, so an event in cycle c is expected at the reading taken in cycle c+1. For every scenario the bench computes the trip cycle as the later of the overcurrent onset and start+blank_len+1, compares it with the end-strobe cycle, and from that predicts both outputs for every cycle of the pulse. The sweeps cover blanking lengths, onset cycles, early and late ends, mid-pulse restarts, and sense values around the limit.

// File: rtl/ocl_pkg.sv
package ocl_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } ocl_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic over;
        logic armed;
    } ocl_evt_t;

    typedef struct packed {
        logic term;
        logic discharge;
    } ocl_out_t;

    localparam ocl_out_t OCL_OUT_RESET = '{term: 1'b0, discharge: 1'b1};

endpackage

// File: rtl/ocl_sense_cmp.sv
module ocl_sense_cmp #(
    parameter int SENSE_W = 11,
    parameter int LIMIT   = 1000
) (
    input  logic [SENSE_W-1:0] sense_i,
    input  logic               flag_i,
    output logic               over_o
);
    localparam logic [SENSE_W-1:0] LIMIT_V = SENSE_W'(LIMIT);

    always_comb begin
        over_o = (sense_i > LIMIT_V) | flag_i;
    end

    // R2: a value at or below the limit with no flag never trips
    always_comb begin
        assert_limit_strict_R2: assert (!((sense_i <= LIMIT_V) && !flag_i && over_o));
    end
endmodule

// File: rtl/ocl_blank_timer.sv
module ocl_blank_timer #(
    parameter int BLANK_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic               clear_i,
    input  logic [BLANK_W-1:0] len_i,
    output logic               blanking_o
);
    logic [BLANK_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign blanking_o = (cnt_q != '0);

    // R3: a load of a nonzero length opens the window on the next cycle
    assert_load_opens_R3: assert property (@(posedge clk) disable iff (rst)
        (load_i && (len_i != '0)) |=> blanking_o);

    // R9: a zero length leaves no window
    assert_zero_len_R9: assert property (@(posedge clk) disable iff (rst)
        (load_i && (len_i == '0)) |=> !blanking_o);
endmodule

// File: rtl/ocl_pulse_fsm.sv
module ocl_pulse_fsm
    import ocl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ocl_evt_t evt_i,
    output logic     active_o,
    output ocl_out_t out_o
);
    ocl_state_e state_q, state_d;
    ocl_out_t   out_q, out_d;

    always_comb begin
        state_d        = state_q;
        out_d          = out_q;
        out_d.term     = 1'b0;
        if (evt_i.start) begin
            state_d         = ST_ACTIVE;
            out_d.discharge = 1'b0;
        end else if (state_q == ST_ACTIVE) begin
            if (evt_i.armed && evt_i.over) begin
                state_d         = ST_IDLE;
                out_d.term      = 1'b1;
                out_d.discharge = 1'b1;
            end else if (evt_i.stop) begin
                state_d         = ST_IDLE;
                out_d.discharge = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            out_q   <= OCL_OUT_RESET;
        end else begin
            state_q <= state_d;
            out_q   <= out_d;
        end
    end

    assign active_o = (state_q == ST_ACTIVE);
    assign out_o    = out_q;

    // R5: after a termination, idle holds until a new start
    assert_no_second_term_R5: assert property (@(posedge clk) disable iff (rst)
        (out_q.term && !evt_i.start) |=> !out_q.term);

    // R7: idle without a start keeps the discharge asserted
    assert_idle_discharge_R7: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_IDLE) && !evt_i.start) |=> out_q.discharge);
endmodule

// File: rtl/ocl_current_limiter.sv
module ocl_current_limiter
    import ocl_pkg::*;
#(
    parameter int SENSE_W = 11,
    parameter int LIMIT   = 1000,
    parameter int BLANK_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pulse_start_i,
    input  logic               pulse_end_i,
    input  logic [SENSE_W-1:0] sense_i,
    input  logic               over_flag_i,
    input  logic [BLANK_W-1:0] blank_len_i,
    output logic               term_o,
    output logic               discharge_o
);
    logic     over;
    logic     blanking;
    logic     active;
    ocl_evt_t evt;
    ocl_out_t outs;

    ocl_sense_cmp #(.SENSE_W(SENSE_W), .LIMIT(LIMIT)) cmp_i (
        .sense_i (sense_i),
        .flag_i  (over_flag_i),
        .over_o  (over)
    );

    ocl_blank_timer #(.BLANK_W(BLANK_W)) blank_i (
        .clk        (clk),
        .rst        (rst),
        .load_i     (pulse_start_i),
        .clear_i    (!active),
        .len_i      (blank_len_i),
        .blanking_o (blanking)
    );

    always_comb begin
        evt.start = pulse_start_i;
        evt.stop  = pulse_end_i;
        evt.over  = over;
        evt.armed = active && !blanking;
    end

    ocl_pulse_fsm fsm_i (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt),
        .active_o (active),
        .out_o    (outs)
    );

    assign term_o      = outs.term;
    assign discharge_o = outs.discharge;

    // R4: the terminate strobe lasts a single cycle
    assert_term_single_R4: assert property (@(posedge clk) disable iff (rst)
        term_o |=> !term_o);

    // R7: a termination comes with the discharge asserted
    assert_term_discharge_R7: assert property (@(posedge clk) disable iff (rst)
        term_o |-> discharge_o);

    // R3 / R11: a start cycle never terminates and releases the discharge
    assert_start_blanked_R3: assert property (@(posedge clk) disable iff (rst)
        pulse_start_i |=> (!term_o && !discharge_o));

    // R8: armed overcurrent wins over a natural end in the same cycle
    assert_over_beats_end_R8: assert property (@(posedge clk) disable iff (rst)
        (active && !blanking && over && !pulse_start_i) |=> term_o);
endmodule

// File: tb/ocl_current_limiter_tb_top.sv
module ocl_current_limiter_tb_top;
    localparam int SW = 11;
    localparam int LIM = 1000;
    localparam int BW = 8;
    localparam int NCYC = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pulse_start_i = 1'b0;
    logic          pulse_end_i = 1'b0;
    logic [SW-1:0] sense_i = '0;
    logic          over_flag_i = 1'b0;
    logic [BW-1:0] blank_len_i = '0;
    logic          term_o;
    logic          discharge_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ocl_current_limiter #(.SENSE_W(SW), .LIMIT(LIM), .BLANK_W(BW)) dut_i (
        .clk(clk), .rst(rst), .pulse_start_i(pulse_start_i), .pulse_end_i(pulse_end_i),
        .sense_i(sense_i), .over_flag_i(over_flag_i), .blank_len_i(blank_len_i),
        .term_o(term_o), .discharge_o(discharge_o)
    );

    task automatic chk(input string req, input logic act, input logic exp, input int cyc);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0b expected %0b", req, cyc, act, exp);
        end
    endtask

    // One pulse: start in cycle 0 (and again in cycle rs if rs >= 0), overcurrent
    // from cycle s (amplitude amp or flag), natural end strobe in cycle e.
    task automatic run_pulse(input int blen, input int s, input int e, input int amp,
                             input bit use_flag, input int rs, input string req);
        int  st;
        int  cc;
        bit  over_on;
        bit  trip;
        int  endc;
        st      = (rs >= 0) ? rs : 0;
        over_on = use_flag || (amp > LIM);
        cc      = (s > st + blen + 1) ? s : st + blen + 1;
        trip    = over_on && (cc <= e);
        endc    = trip ? cc : e;
        for (int k = 0; k < NCYC; k++) begin
            @(negedge clk);
            chk({req, " term"}, term_o, (trip && k == cc + 1), k);
            chk({req, " discharge R7"}, discharge_o, (k == 0) ? 1'b1 : (k > endc), k);
            pulse_start_i = (k == 0) || (k == rs);
            pulse_end_i   = (k == e);
            blank_len_i   = BW'(blen);
            if (k >= s) begin
                sense_i     = use_flag ? SW'(0) : SW'(amp);
                over_flag_i = use_flag;
            end else begin
                sense_i     = SW'(LIM - 200);
                over_flag_i = 1'b0;
            end
        end
        @(negedge clk);
        pulse_start_i = 1'b0;
        pulse_end_i   = 1'b0;
        sense_i       = '0;
        over_flag_i   = 1'b0;
        chk({req, " idle discharge R7"}, discharge_o, 1'b1, NCYC);
        chk({req, " idle term R5"}, term_o, 1'b0, NCYC);
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 term in reset", term_o, 1'b0, 0);
        chk("R1 discharge in reset", discharge_o, 1'b1, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 term after reset", term_o, 1'b0, 0);
        chk("R1 discharge after reset", discharge_o, 1'b1, 0);

        // R3 R4 R6 R9: sweep blank length, onset and end (s=99: no overcurrent)
        for (int bl = 0; bl <= 6; bl++)
            for (int s = 0; s <= 10; s++)
                for (int ev = 0; ev < 2; ev++)
                    run_pulse(bl, (s == 10) ? 99 : s, (ev == 0) ? 3 : 14,
                              LIM + 1, 1'b0, -1, "R3/R4/R6/R9 sweep");

        // R2: threshold is strict, flag path trips too
        run_pulse(0, 2, 14, LIM - 1, 1'b0, -1, "R2 below limit");
        run_pulse(0, 2, 14, LIM,     1'b0, -1, "R2 at limit");
        run_pulse(0, 2, 14, LIM + 1, 1'b0, -1, "R2 above limit");
        for (int bl = 0; bl <= 4; bl++)
            run_pulse(bl, 1, 14, 0, 1'b1, -1, "R2 flag");

        // R8: overcurrent and natural end in the same armed cycle
        run_pulse(2, 5, 5, LIM + 50, 1'b0, -1, "R8 same cycle");
        run_pulse(0, 1, 1, 0, 1'b1, -1, "R8 same cycle flag");

        // R11: restart during blanking and while armed
        run_pulse(3, 0, 14, LIM + 1, 1'b0, 2, "R11 restart in blank");
        run_pulse(2, 6, 14, LIM + 1, 1'b0, 4, "R11 restart armed");

        // R10 R5: persistent overcurrent over consecutive pulses
        for (int p = 0; p < 6; p++)
            run_pulse(2, 0, 14, 2000, 1'b0, -1, "R10 persistent");

        // R3: long blanking hides the whole pulse
        run_pulse(20, 0, 14, 2000, 1'b0, -1, "R3 long blank");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule